// File: doc/BRIEF.md
# Bus Cycle Sequencer with Halt, Retry and Single-Step

This block runs bus cycles on behalf of a processor core: reads, writes, and indivisible read-modify-write (RMW) cycles. A cycle starts from a request only while the bus is granted and the active-low halt input is negated. The block drives an address strobe and a data strobe, and the cycle ends on an active-low data acknowledge. The address, function code and write data are captured when the request is accepted. The bus outputs are driven from these captured values, so a cycle that is repeated presents exactly the same values.

An active-low bus-error input can end a cycle. Bus error alone raises a one-clock exception pulse to the core, together with the captured address and function code. Bus error together with halt makes the block release the bus, stop driving data, and wait. When bus error and then halt have been negated, the identical cycle is reissued. An RMW cycle is never reissued: a bus error inside it always raises the exception. Halt asserted on its own stops the sequencer once the current cycle has completed. Toggling halt lets a debugger step through one bus cycle at a time.

Top module: `busseq_ctrl`

## Requirements
- R1: While reset is asserted, as_n and ds_n are high, dout_oe is low, and done and berr_exc are low.
- R2: A read request with req_kind 0 is accepted while req_ready is high, which needs IDLE, halt_n high and bus_grant high. as_n falls on the next clock and ds_n falls one clock after that. The cycle ends on the first clock at which dtack_n is low. done is then high for exactly one clock with rdata equal to din as sampled at that clock.
- R3: A write request with req_kind 1 drives rw low, dout_oe high and dout equal to the captured write data for as long as as_n is low.
- R4: If berr_n is low at a clock in the data phase while halt_n is high, berr_exc is high for exactly one clock on the next clock, with exc_addr and exc_fc equal to the cycle's address and function code, and done stays low.
- R5: If berr_n and halt_n are both low at a clock in the data phase of a read or write, no exception is raised. as_n and ds_n stay high and dout_oe stays low until halt_n and berr_n are both high.
- R6: After R5, the retried cycle starts on the first clock at which halt_n, berr_n and bus_grant are all high. It uses the same bus_addr, bus_fc, rw and dout, and it ends with done like a normal cycle.
- R7: If halt_n is low when a cycle completes, the cycle still ends with done. No new cycle starts and req_ready stays low for as long as halt_n is held low.
- R8: In single-step use, negating halt_n lets exactly one bus cycle begin. Asserting halt_n again before that cycle ends stops the sequencer once it completes.
- R9: An RMW request with req_kind 2 keeps as_n low from the start of its read phase through the end of its write phase. rw is high in the read phase and low in the write phase, and rdata holds the read-phase data.
- R10: A bus error in either phase of an RMW cycle raises berr_exc, whatever the level of halt_n.
- R11: No cycle begins while bus_grant is low.
- R12: When berr_n and dtack_n are both low at the same clock, the bus error wins and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_kind | input | 2 | Cycle type: 0 read, 1 write, 2 read-modify-write, 3 treated as read |
| req_addr | input | AW | Request address |
| req_fc | input | FCW | Request function code |
| req_wdata | input | DW | Write data (the write part of an RMW cycle also uses it) |
| req_ready | output | 1 | Request accepted at this clock when req_valid is high |
| bus_grant | input | 1 | Bus mastership granted by the external arbiter |
| berr_n | input | 1 | Active-low bus error |
| halt_n | input | 1 | Active-low halt |
| dtack_n | input | 1 | Active-low data acknowledge |
| din | input | DW | Data read from the bus |
| bus_addr | output | AW | Captured address driven on the bus |
| bus_fc | output | FCW | Captured function code |
| as_n | output | 1 | Active-low address strobe |
| ds_n | output | 1 | Active-low data strobe |
| rw | output | 1 | 1 for read, 0 for write |
| dout | output | DW | Write data |
| dout_oe | output | 1 | Data bus output enable (low means tri-stated) |
| done | output | 1 | One-clock pulse when a cycle completes |
| rdata | output | DW | Data captured from the last read |
| berr_exc | output | 1 | One-clock bus-error exception pulse |
| exc_addr | output | AW | Address of the faulting cycle |
| exc_fc | output | FCW | Function code of the faulting cycle |

## Verification
The bound assertions check on every clock that a new cycle only starts after a granted idle clock. They also check that halt keeps the halted and retry-wait states parked, that the exception pulse lasts one clock, that a bus error in an RMW always leads to the exception, that the address strobe stays low across the RMW turnaround, and that a bus error masks a simultaneous acknowledge. Other properties need whole scenarios: that a retry repeats the same address, function code and write data, that bus error is released before halt, that single-step lets exactly one cycle through, and that the data bus stays tri-stated for the whole retry wait. The bench shows these with directed sequences mixed with seeded random cycles of varied latency and outcome.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DWAIT = 3'd2,
        ST_END   = 3'd3,
        ST_HALT  = 3'd4,
        ST_RWAIT = 3'd5,
        ST_BEXC  = 3'd6
    } bstate_e;

    localparam logic [1:0] K_RD  = 2'd0;
    localparam logic [1:0] K_WR  = 2'd1;
    localparam logic [1:0] K_RMW = 2'd2;

endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
    import busseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       bus_grant,
    input  logic       berr_n,
    input  logic       halt_n,
    input  logic       dtack_n,
    output bstate_e    st,
    output logic [1:0] kind,
    output logic       wph,
    output logic       ready,
    output logic       load,
    output logic       cap
);

    typedef struct packed {
        bstate_e    st;
        logic [1:0] kind;
        logic       wph;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        load  = 1'b0;
        cap   = 1'b0;
        ready = (s_q.st == ST_IDLE) && halt_n && bus_grant;
        unique case (s_q.st)
            ST_IDLE: begin
                if (ready && req_valid) begin
                    s_d.st   = ST_ADDR;
                    s_d.kind = (req_kind == K_RMW) ? K_RMW :
                               (req_kind == K_WR)  ? K_WR  : K_RD;
                    s_d.wph  = (req_kind == K_WR);
                    load     = 1'b1;
                end
            end
            ST_ADDR: s_d.st = ST_DWAIT;
            ST_DWAIT: begin
                if (!berr_n) begin
                    // bus error outranks acknowledge; RMW never retries
                    s_d.st = (s_q.kind == K_RMW || halt_n) ? ST_BEXC : ST_RWAIT;
                end else if (!dtack_n) begin
                    cap = !s_q.wph;
                    if (s_q.kind == K_RMW && !s_q.wph) begin
                        s_d.st  = ST_ADDR;
                        s_d.wph = 1'b1;
                    end else begin
                        s_d.st = ST_END;
                    end
                end
            end
            ST_END:   s_d.st = halt_n ? ST_IDLE : ST_HALT;
            ST_HALT:  if (halt_n) s_d.st = ST_IDLE;
            ST_RWAIT: if (halt_n && berr_n && bus_grant) s_d.st = ST_ADDR;
            ST_BEXC:  s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, kind: K_RD, wph: 1'b0};
        else        s_q <= s_d;
    end

    assign st   = s_q.st;
    assign kind = s_q.kind;
    assign wph  = s_q.wph;

endmodule

// File: rtl/busseq_latch.sv
module busseq_latch #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           cap,
    input  logic [AW-1:0]  req_addr,
    input  logic [FCW-1:0] req_fc,
    input  logic [DW-1:0]  req_wdata,
    input  logic [DW-1:0]  din,
    output logic [AW-1:0]  addr,
    output logic [FCW-1:0] fc,
    output logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [FCW-1:0] fc;
        logic [DW-1:0]  wd;
        logic [DW-1:0]  rd;
    } rec_t;

    rec_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.addr = req_addr;
            r_d.fc   = req_fc;
            r_d.wd   = req_wdata;
        end
        if (cap) r_d.rd = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr  = r_q.addr;
    assign fc    = r_q.fc;
    assign wdata = r_q.wd;
    assign rdata = r_q.rd;

endmodule

// File: rtl/busseq_drive.sv
module busseq_drive
    import busseq_pkg::*;
(
    input  bstate_e st,
    input  logic    wph,
    output logic    as_n,
    output logic    ds_n,
    output logic    rw,
    output logic    dout_oe,
    output logic    done,
    output logic    berr_exc
);

    logic on_bus;

    always_comb begin
        on_bus   = (st == ST_ADDR) || (st == ST_DWAIT);
        as_n     = !on_bus;
        ds_n     = (st != ST_DWAIT);
        rw       = !wph;
        dout_oe  = on_bus && wph;
        done     = (st == ST_END);
        berr_exc = (st == ST_BEXC);
    end

endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
    import busseq_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_kind,
    input  logic [AW-1:0]  req_addr,
    input  logic [FCW-1:0] req_fc,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    input  logic           bus_grant,
    input  logic           berr_n,
    input  logic           halt_n,
    input  logic           dtack_n,
    input  logic [DW-1:0]  din,
    output logic [AW-1:0]  bus_addr,
    output logic [FCW-1:0] bus_fc,
    output logic           as_n,
    output logic           ds_n,
    output logic           rw,
    output logic [DW-1:0]  dout,
    output logic           dout_oe,
    output logic           done,
    output logic [DW-1:0]  rdata,
    output logic           berr_exc,
    output logic [AW-1:0]  exc_addr,
    output logic [FCW-1:0] exc_fc
);

    bstate_e    st;
    logic [1:0] kind;
    logic       wph;
    logic       load;
    logic       cap;

    busseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .bus_grant(bus_grant), .berr_n(berr_n), .halt_n(halt_n), .dtack_n(dtack_n),
        .st(st), .kind(kind), .wph(wph), .ready(req_ready), .load(load), .cap(cap)
    );

    busseq_latch #(.AW(AW), .DW(DW), .FCW(FCW)) u_lat (
        .clk(clk), .rst_n(rst_n), .load(load), .cap(cap),
        .req_addr(req_addr), .req_fc(req_fc), .req_wdata(req_wdata), .din(din),
        .addr(bus_addr), .fc(bus_fc), .wdata(dout), .rdata(rdata)
    );

    busseq_drive u_drv (
        .st(st), .wph(wph), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .dout_oe(dout_oe), .done(done), .berr_exc(berr_exc)
    );

    assign exc_addr = bus_addr;
    assign exc_fc   = bus_fc;

endmodule

// File: rtl/busseq_ctrl_chk.sv
module busseq_ctrl_chk
    import busseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input bstate_e    st,
    input logic [1:0] kind,
    input logic       wph,
    input logic       as_n,
    input logic       berr_n,
    input logic       halt_n,
    input logic       dtack_n,
    input logic       bus_grant,
    input logic       berr_exc,
    input logic       done
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (as_n && !berr_exc && !done));

    a_r11_grant_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && $past(st) == ST_IDLE) |-> $past(bus_grant));

    a_r7_halt_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !halt_n) |=> (st == ST_HALT));

    a_r5_retry_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RWAIT && !halt_n) |=> (st == ST_RWAIT && as_n));

    a_r4_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
        berr_exc |=> !berr_exc);

    a_r10_rmw_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DWAIT && kind == K_RMW && !berr_n) |=> berr_exc);

    a_r9_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DWAIT && kind == K_RMW && !wph && !dtack_n && berr_n) |=> !as_n);

    a_r12_berr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DWAIT && !berr_n) |=> !done);

endmodule

bind busseq_ctrl busseq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .kind(kind), .wph(wph), .as_n(as_n),
    .berr_n(berr_n), .halt_n(halt_n), .dtack_n(dtack_n), .bus_grant(bus_grant),
    .berr_exc(berr_exc), .done(done)
);

// File: tb/busseq_ctrl_test.sv
module busseq_ctrl_test;

    localparam int AW = 24, DW = 16, FCW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [1:0]     req_kind = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [FCW-1:0] req_fc = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ready;
    logic           bus_grant = 1'b1, berr_n = 1'b1, halt_n = 1'b1, dtack_n = 1'b1;
    logic [DW-1:0]  din = '0;
    logic [AW-1:0]  bus_addr, exc_addr;
    logic [FCW-1:0] bus_fc, exc_fc;
    logic           as_n, ds_n, rw, dout_oe, done, berr_exc;
    logic [DW-1:0]  dout, rdata;

    int total = 0, bad = 0, falls = 0;
    logic prev_as = 1'b1;

    always #4 clk = ~clk;

    busseq_ctrl #(.AW(AW), .DW(DW), .FCW(FCW)) uut (.*);

    always @(negedge clk) begin
        if (prev_as && !as_n) falls++;
        prev_as = as_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_rw(input int kind);
        return (kind == 1) ? 1'b0 : 1'b1;
    endfunction

    // mode 0 normal, 1 bus error, 2 retry, 3 error+ack, 4 rmw error with halt
    task automatic run_cycle(input int kind, input int mode, input int lat,
                             input logic [AW-1:0] a, input logic [FCW-1:0] f,
                             input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                             input int hold);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind[1:0]; req_addr = a; req_fc = f; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 as_n low", as_n, 0);
        chk("R2 ds_n high in addr", ds_n, 1);
        chk("R2 addr", bus_addr, a);
        chk("R2 fc", bus_fc, f);
        chk("R3 rw", rw, exp_rw(kind));
        if (kind == 1) begin
            chk("R3 oe", dout_oe, 1);
            chk("R3 dout", dout, wd);
        end
        @(negedge clk);
        chk("R2 ds_n low", ds_n, 0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R2 waits for ack", {ds_n, done}, 2'b00);
        end
        if (mode == 0) begin
            dtack_n = 1'b0; din = rd;
            @(negedge clk);
            dtack_n = 1'b1;
            if (kind == 2) begin
                chk("R9 as held", as_n, 0);
                chk("R9 write rw", rw, 0);
                chk("R9 write oe", dout_oe, 1);
                chk("R9 write data", dout, wd);
                @(negedge clk);
                chk("R9 write strobes", {as_n, ds_n}, 2'b00);
                dtack_n = 1'b0; din = ~rd;
                @(negedge clk);
                dtack_n = 1'b1;
            end
            chk("R2 done", done, 1);
            if (kind != 1) chk("R2 rdata", rdata, rd);
            @(negedge clk);
            chk("R2 done single", {done, as_n}, 2'b01);
        end else if (mode == 1 || mode == 3) begin
            berr_n = 1'b0;
            if (mode == 3) dtack_n = 1'b0;
            @(negedge clk);
            berr_n = 1'b1; dtack_n = 1'b1;
            chk(mode == 3 ? "R12 exc" : "R4 exc", berr_exc, 1);
            chk("R12 no done", done, 0);
            chk("R4 exc addr", exc_addr, a);
            chk("R4 exc fc", exc_fc, f);
            @(negedge clk);
            chk("R4 exc single", berr_exc, 0);
        end else if (mode == 2) begin
            berr_n = 1'b0; halt_n = 1'b0;
            @(negedge clk);
            berr_n = 1'b1;
            chk("R5 quiet", {as_n, ds_n, dout_oe, berr_exc}, 4'b1100);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk("R5 still quiet", {as_n, ds_n, dout_oe, berr_exc, done}, 5'b11000);
            end
            halt_n = 1'b1;
            @(negedge clk);
            chk("R6 reissue", as_n, 0);
            chk("R6 addr", bus_addr, a);
            chk("R6 fc", bus_fc, f);
            chk("R6 rw", rw, exp_rw(kind));
            if (kind == 1) chk("R6 data", {dout_oe, dout}, {1'b1, wd});
            @(negedge clk);
            dtack_n = 1'b0; din = rd;
            @(negedge clk);
            dtack_n = 1'b1;
            chk("R6 done", done, 1);
            if (kind != 1) chk("R6 rdata", rdata, rd);
            @(negedge clk);
        end else begin
            berr_n = 1'b0; halt_n = 1'b0;
            @(negedge clk);
            berr_n = 1'b1; halt_n = 1'b1;
            chk("R10 rmw exc", berr_exc, 1);
            chk("R10 exc addr", exc_addr, a);
            @(negedge clk);
            chk("R10 exc single", berr_exc, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 strobes", {as_n, ds_n, dout_oe}, 3'b110);
        chk("R1 pulses", {done, berr_exc}, 2'b00);
        rst_n = 1'b1;

        run_cycle(0, 0, 0, 24'h00_1000, 3'd5, 16'h0, 16'hA5A5, 1);
        run_cycle(1, 0, 2, 24'hFF_FFFE, 3'd1, 16'hFFFF, 16'h0, 1);
        run_cycle(0, 1, 1, 24'h12_3456, 3'd6, 16'h0, 16'h0, 1);
        run_cycle(1, 3, 0, 24'h00_0002, 3'd2, 16'h1234, 16'h0, 1);
        run_cycle(1, 2, 1, 24'h40_0000, 3'd1, 16'hBEEF, 16'h0, 3);
        run_cycle(2, 0, 1, 24'h00_8000, 3'd5, 16'h5A5A, 16'hC3C3, 1);
        run_cycle(2, 4, 0, 24'h00_8002, 3'd5, 16'h0001, 16'h0, 1);

        // R11: no start without grant
        @(negedge clk);
        bus_grant = 1'b0; req_valid = 1'b1; req_kind = 2'd0; req_addr = 24'h77;
        repeat (4) begin
            @(negedge clk);
            chk("R11 no start", {as_n, req_ready}, 2'b10);
        end
        bus_grant = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 start after grant", as_n, 0);
        @(negedge clk);
        dtack_n = 1'b0; din = 16'h0077;
        @(negedge clk);
        dtack_n = 1'b1;
        chk("R11 done", done, 1);
        @(negedge clk);

        // R7 / R8: halt then single-step
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 24'h99;
        @(negedge clk);
        halt_n = 1'b0;
        @(negedge clk);
        dtack_n = 1'b0; din = 16'h0099;
        @(negedge clk);
        dtack_n = 1'b1;
        chk("R7 cycle completes", done, 1);
        repeat (5) begin
            @(negedge clk);
            chk("R7 halted", {as_n, req_ready}, 2'b10);
        end
        base = falls;
        halt_n = 1'b1;
        @(negedge clk);
        chk("R8 ready after release", req_ready, 1);
        @(negedge clk);
        chk("R8 one cycle begins", as_n, 0);
        halt_n = 1'b0;
        @(negedge clk);
        dtack_n = 1'b0;
        @(negedge clk);
        dtack_n = 1'b1;
        chk("R8 stepped cycle done", done, 1);
        repeat (6) begin
            @(negedge clk);
            chk("R8 stops after step", as_n, 1);
        end
        chk("R8 exactly one cycle", falls - base, 1);
        req_valid = 1'b0; halt_n = 1'b1;
        repeat (2) @(negedge clk);

        // seeded random mix
        for (int i = 0; i < 40; i++) begin
            int k, m, md;
            m = $urandom % 8;
            k = $urandom % 3;
            if (k == 2) md = (m < 6) ? 0 : 4;
            else md = (m < 4) ? 0 : (m == 4) ? 1 : (m == 5) ? 3 : 2;
            run_cycle(k, md, $urandom % 4, AW'($urandom), FCW'($urandom),
                      DW'($urandom), DW'($urandom), 1 + $urandom % 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule